// File: doc/BRIEF.md
# Indirectly Addressed GPIO Port

An eight-pin general-purpose I/O port whose configuration is reached through a two-register window. The CPU first writes a subregister number into the port address register. It then reads or writes the port control register, which acts on whichever configuration subregister that number selects. The subregisters are the pin direction, the alternate-function enable and two alternate-function set registers. The output data register and the input data register are reached directly.

Each pin is driven in one of two ways. As plain GPIO, the direction bit decides between driving the output data bit and tristating the pin. As an alternate function, one of four peripheral functions is chosen by the pair of set bits, and that function supplies the output value and the output enable. The alternate-function enable takes priority over the direction bit. Pin inputs pass through a two-flop synchronizer into the input data register. The register value is handed back to every alternate function.

The bus interface is single-cycle. Writes take effect on the clock edge, and read data is combinational from the current offset. Bus offsets are: 0 = port address register, 1 = port control register, 2 = output data register, 3 = input data register (read-only).

Top module: `gpio_ind_port`

## Requirements
- R1: The port address register (offset 0) resets to 00H, and a write to offset 0 is read back unchanged on the next cycle.
- R2: With subaddress 01H, offset 1 reads and writes the direction subregister. The direction subregister resets to FFH.
- R3: With subaddress 02H, offset 1 reads and writes the alternate-function enable subregister. It resets to 00H.
- R4: Subaddress 03H selects the set-1 subregister and 04H selects the set-2 subregister, each through offset 1. Both reset to 00H.
- R5: With any other subaddress, a read of offset 1 returns 00H, and a write to offset 1 changes no subregister.
- R6: A pin with alternate function off and direction bit 0 has pin_oe high, and pin_out equals its bit of the output data register (offset 2, reset 00H).
- R7: A pin with alternate function off and direction bit 1 has pin_oe low.
- R8: A pin with its enable bit set ignores its direction bit. Its function index is f = 2*set2[i] + set1[i], and the pin takes pin_out = alt_out[f*8+i] and pin_oe = alt_oe[f*8+i].
- R9: The value on pin_in appears in the input data register (offset 3) and on alt_in three clocks after it is sampled. The register resets to 00H.
- R10: Writes to offset 3 are ignored: the output data register and all subregisters keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the bus offset |
| bus_off | input | 2 | Bus offset: 0 address, 1 control, 2 output data, 3 input data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_off |
| pin_in | input | 8 | Pad input values |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables, 1 = drive |
| alt_out | input | 32 | Alternate-function outputs, function f pin i at bit f*8+i |
| alt_oe | input | 32 | Alternate-function output enables, same layout |
| alt_in | output | 8 | Synchronized pin inputs returned to every alternate function |

## Verification
The bench writes to subaddresses that select no subregister, such as 00H and 05H. It then reads back all four real subregisters, which catches a decoder whose default case falls through onto the direction register. It sets alternate-function enables on pins whose direction bit is 0 and on pins whose direction bit is 1, so a mux that lets the direction bit win would show the wrong pin_oe. It walks all four set-bit combinations and varies alt_out and alt_oe on every cycle, which exposes swapped set registers or a wrong bit index. It changes pin_in every cycle and predicts the input register three clocks later, so a pipeline that is one stage short or long is reported.

// File: rtl/gpio_ind_pkg.sv
package gpio_ind_pkg;
  localparam int unsigned DW = 8;
  localparam logic [1:0] OFF_ADDR = 2'd0;
  localparam logic [1:0] OFF_CTL  = 2'd1;
  localparam logic [1:0] OFF_ODR  = 2'd2;
  localparam logic [1:0] OFF_IDR  = 2'd3;
  localparam logic [DW-1:0] SUB_DIR  = 8'h01;
  localparam logic [DW-1:0] SUB_AFEN = 8'h02;
  localparam logic [DW-1:0] SUB_SET1 = 8'h03;
  localparam logic [DW-1:0] SUB_SET2 = 8'h04;

  typedef struct packed {
    logic [DW-1:0] dir;
    logic [DW-1:0] afen;
    logic [DW-1:0] set1;
    logic [DW-1:0] set2;
    logic [DW-1:0] odr;
  } port_cfg_t;
endpackage

// File: rtl/gpio_ind_regs.sv
module gpio_ind_regs
  import gpio_ind_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_off,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] idr,
  output logic [DW-1:0] bus_rdata,
  output port_cfg_t     cfg
);
  logic [DW-1:0] addr_q, addr_d;
  port_cfg_t     cfg_q, cfg_d;
  logic          addr_en, cfg_en;
  logic [DW-1:0] sub_rd;

  always_comb begin
    cfg_d   = cfg_q;
    addr_d  = addr_q;
    addr_en = bus_wr && (bus_off == OFF_ADDR);
    cfg_en  = 1'b0;
    if (addr_en) addr_d = bus_wdata;
    if (bus_wr && bus_off == OFF_ODR) begin
      cfg_d.odr = bus_wdata;
      cfg_en    = 1'b1;
    end
    if (bus_wr && bus_off == OFF_CTL) begin
      cfg_en = 1'b1;
      case (addr_q)
        SUB_DIR:  cfg_d.dir  = bus_wdata;
        SUB_AFEN: cfg_d.afen = bus_wdata;
        SUB_SET1: cfg_d.set1 = bus_wdata;
        SUB_SET2: cfg_d.set2 = bus_wdata;
        default:  cfg_en     = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.dir  <= '1;
      cfg_q.afen <= '0;
      cfg_q.set1 <= '0;
      cfg_q.set2 <= '0;
      cfg_q.odr  <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    case (addr_q)
      SUB_DIR:  sub_rd = cfg_q.dir;
      SUB_AFEN: sub_rd = cfg_q.afen;
      SUB_SET1: sub_rd = cfg_q.set1;
      SUB_SET2: sub_rd = cfg_q.set2;
      default:  sub_rd = '0;
    endcase
    case (bus_off)
      OFF_ADDR: bus_rdata = addr_q;
      OFF_CTL:  bus_rdata = sub_rd;
      OFF_ODR:  bus_rdata = cfg_q.odr;
      default:  bus_rdata = idr;
    endcase
  end

  assign cfg = cfg_q;

  // R1
  addr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_off == OFF_ADDR) |=> (addr_q == $past(bus_wdata)));

  // R5
  unimpl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_off == OFF_CTL && addr_q != SUB_DIR && addr_q != SUB_AFEN &&
     addr_q != SUB_SET1 && addr_q != SUB_SET2) |=> $stable(cfg_q));

  // R10
  idr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_off == OFF_IDR) |=> $stable(cfg_q));
endmodule

// File: rtl/gpio_ind_sync.sv
module gpio_ind_sync
  import gpio_ind_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] idr
);
  logic [DW-1:0] s1_q, s2_q, idr_q;
  logic [1:0]    age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= '0;
      s2_q  <= '0;
      idr_q <= '0;
    end else begin
      s1_q  <= pin_in;
      s2_q  <= s1_q;
      idr_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assign idr = idr_q;

  // R9
  in_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (idr_q == $past(pin_in, 3)));
endmodule

// File: rtl/gpio_ind_pinmux.sv
module gpio_ind_pinmux
  import gpio_ind_pkg::*;
#(
  parameter int unsigned NFUNC = 4
)(
  input  port_cfg_t           cfg,
  input  logic [NFUNC*DW-1:0] alt_out,
  input  logic [NFUNC*DW-1:0] alt_oe,
  output logic [DW-1:0]       pin_out,
  output logic [DW-1:0]       pin_oe
);
  for (genvar i = 0; i < DW; i++) begin : g_pin
    logic [1:0] fsel;
    assign fsel = {cfg.set2[i], cfg.set1[i]};
    always_comb begin
      if (cfg.afen[i]) begin
        pin_out[i] = alt_out[fsel*DW + i];
        pin_oe[i]  = alt_oe[fsel*DW + i];
      end else begin
        pin_out[i] = cfg.odr[i];
        pin_oe[i]  = ~cfg.dir[i];
      end
    end
  end
endmodule

// File: rtl/gpio_ind_port.sv
module gpio_ind_port
  import gpio_ind_pkg::*;
#(
  parameter int unsigned NFUNC = 4
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [1:0]          bus_off,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  logic [DW-1:0]       pin_in,
  output logic [DW-1:0]       pin_out,
  output logic [DW-1:0]       pin_oe,
  input  logic [NFUNC*DW-1:0] alt_out,
  input  logic [NFUNC*DW-1:0] alt_oe,
  output logic [DW-1:0]       alt_in
);
  logic      rs1_q, rs2_q;
  logic [DW-1:0] idr;
  port_cfg_t cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  gpio_ind_regs u_regs (
    .clk(clk), .rst_n(rs2_q), .bus_wr(bus_wr), .bus_off(bus_off),
    .bus_wdata(bus_wdata), .idr(idr), .bus_rdata(bus_rdata), .cfg(cfg)
  );

  gpio_ind_sync u_sync (
    .clk(clk), .rst_n(rs2_q), .pin_in(pin_in), .idr(idr)
  );

  gpio_ind_pinmux #(.NFUNC(NFUNC)) u_mux (
    .cfg(cfg), .alt_out(alt_out), .alt_oe(alt_oe),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign alt_in = idr;

  // R8
  af_over_chk: assert property (@(posedge clk) disable iff (!rs2_q)
    (cfg.afen == 8'hFF && cfg.set1 == 8'h00 && cfg.set2 == 8'h00) |->
      (pin_oe == alt_oe[DW-1:0] && pin_out == alt_out[DW-1:0]));

  // R7
  in_tri_chk: assert property (@(posedge clk) disable iff (!rs2_q)
    (cfg.afen == 8'h00 && cfg.dir == 8'hFF) |-> (pin_oe == 8'h00));
endmodule

// File: tb/gpio_ind_port_test.sv
module gpio_ind_port_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [1:0]  bus_off;
  logic [7:0]  bus_wdata, bus_rdata, pin_in, pin_out, pin_oe, alt_in;
  logic [31:0] alt_out, alt_oe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural model state
  logic [7:0] m_addr, m_dir, m_afen, m_s1, m_s2, m_odr;
  logic [7:0] hist [$];

  always #5 clk = ~clk;

  gpio_ind_port uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_off(bus_off),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .alt_out(alt_out), .alt_oe(alt_oe),
    .alt_in(alt_in)
  );

  function automatic logic [7:0] m_idr();
    return hist[0];
  endfunction

  function automatic logic [7:0] m_rd();
    case (bus_off)
      2'd0: return m_addr;
      2'd1: case (m_addr)
              8'h01: return m_dir;
              8'h02: return m_afen;
              8'h03: return m_s1;
              8'h04: return m_s2;
              default: return 8'h00;
            endcase
      2'd2: return m_odr;
      default: return m_idr();
    endcase
  endfunction

  task automatic compare(string tag);
    logic [7:0] eo, ee;
    for (int i = 0; i < 8; i++) begin
      int f;
      f = 2 * m_s2[i] + m_s1[i];
      if (m_afen[i]) begin
        eo[i] = alt_out[f*8+i];
        ee[i] = alt_oe[f*8+i];
      end else begin
        eo[i] = m_odr[i];
        ee[i] = ~m_dir[i];
      end
    end
    checks++;
    if (pin_oe !== ee || pin_out !== eo || bus_rdata !== m_rd() || alt_in !== m_idr()) begin
      failures++;
      $display("FAIL %s oe=%h/%h out=%h/%h rdata=%h/%h alt_in=%h/%h", tag,
               pin_oe, ee, pin_out, eo, bus_rdata, m_rd(), alt_in, m_idr());
    end
  endtask

  // one bus cycle: drive at negedge, compare, then update model at posedge
  task automatic step(string tag, bit wr, logic [1:0] off, logic [7:0] d,
                      logic [7:0] pins, logic [31:0] ao, logic [31:0] ae);
    @(negedge clk);
    bus_wr = wr; bus_off = off; bus_wdata = d;
    pin_in = pins; alt_out = ao; alt_oe = ae;
    #1 compare(tag);
    @(posedge clk);
    if (wr) begin
      case (off)
        2'd0: m_addr = d;
        2'd1: case (m_addr)
                8'h01: m_dir = d;
                8'h02: m_afen = d;
                8'h03: m_s1 = d;
                8'h04: m_s2 = d;
                default: ;
              endcase
        2'd2: m_odr = d;
        default: ;
      endcase
    end
    void'(hist.pop_front());
    hist.push_back(pins);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    rst_n = 1'b0; bus_wr = 0; bus_off = 0; bus_wdata = 0;
    pin_in = 0; alt_out = 0; alt_oe = 0;
    m_addr = 0; m_dir = 8'hFF; m_afen = 0; m_s1 = 0; m_s2 = 0; m_odr = 0;
    for (int k = 0; k < 3; k++) hist.push_back(8'h00);
    repeat (3) @(posedge clk);
    #1;
    // reset state: R1, R7, R9
    compare("R1 R7 R9 reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) step("R1 R9 idle after reset", 0, 2'd0, 0, 0, 0, 0);
    step("R1 addr reads 00", 0, 2'd0, 0, 0, 0, 0);
    step("R5 control at sub 00 reads 00", 1, 2'd1, 8'h5A, 0, 0, 0);
    step("R2 R3 R4 R10 after sub00 write", 0, 2'd2, 0, 0, 0, 0);
    step("R1 write addr 01", 1, 2'd0, 8'h01, 0, 0, 0);
    step("R2 dir reset FF", 0, 2'd1, 0, 0, 0, 0);
    step("R2 write dir 0F", 1, 2'd1, 8'h0F, 0, 0, 0);
    step("R6 write odr A5", 1, 2'd2, 8'hA5, 0, 0, 0);
    step("R6 R7 gpio drive", 0, 2'd1, 0, 8'h3C, 0, 0);
    step("R3 addr 02", 1, 2'd0, 8'h02, 8'hC3, 0, 0);
    step("R3 afen reset 00", 0, 2'd1, 0, 8'h11, 0, 0);
    step("R4 addr 03", 1, 2'd0, 8'h03, 8'h22, 0, 0);
    step("R4 set1 reset 00", 0, 2'd1, 0, 8'h44, 0, 0);
    step("R4 addr 04", 1, 2'd0, 8'h04, 8'h88, 0, 0);
    step("R4 set2 reset 00", 0, 2'd1, 0, 8'hFF, 0, 0);
    step("R1 addr 05", 1, 2'd0, 8'h05, 8'h00, 0, 0);
    step("R5 write sub 05", 1, 2'd1, 8'hFF, 8'h01, 0, 0);
    step("R5 read sub 05", 0, 2'd1, 0, 8'h02, 0, 0);
    step("R10 write idr", 1, 2'd3, 8'h77, 8'h04, 0, 0);
    step("R10 odr kept", 0, 2'd2, 0, 8'h08, 0, 0);
    step("R9 idr read", 0, 2'd3, 0, 8'h10, 0, 0);
    step("R5 addr 01", 1, 2'd0, 8'h01, 8'h20, 0, 0);
    step("R5 dir kept", 0, 2'd1, 0, 8'h40, 0, 0);
    // configure alternate functions: R8 with every set combination
    step("R4 addr 03", 1, 2'd0, 8'h03, 0, 0, 0);
    step("R4 set1 CC", 1, 2'd1, 8'hCC, 0, 0, 0);
    step("R4 addr 04", 1, 2'd0, 8'h04, 0, 0, 0);
    step("R4 set2 F0", 1, 2'd1, 8'hF0, 0, 0, 0);
    step("R3 addr 02", 1, 2'd0, 8'h02, 0, 0, 0);
    step("R3 afen 3C", 1, 2'd1, 8'h3C, 0, 0, 0);
    lf = 32'hACE1_2345;
    for (int n = 0; n < 60; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step("R8 R9 alt mux random", 0, 2'(n % 4), 0, lf[7:0], lf, ~{lf[15:0], lf[31:16]});
    end
    step("R3 afen FF", 1, 2'd1, 8'hFF, 0, 32'h1234_5678, 32'h9ABC_DEF0);
    for (int n = 0; n < 40; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step("R8 all alt", 0, 2'(n % 4), 0, lf[15:8], {lf[7:0], lf[31:8]}, lf);
    end
    step("R3 afen 00", 1, 2'd1, 8'h00, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step("R6 R7 back to gpio", 0, 2'd2, 0, 8'h99, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    for (int n = 0; n < 6; n++) step("R9 drain", 0, 2'd3, 0, 8'h5A ^ 8'(n), 0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule